// File: doc/BRIEF.md
# Strict-plus-WFQ transmit arbiter

This block chooses which of five transmit clients of one port may send its next packet. Client 0 is management, clients 1 and 2 are debug sources, and clients 3 and 4 are the two traffic classes. Each client is classed by two bitmaps as strict, weighted (WFQ) or plain. Strict clients are served first, in the order set by a programmable priority map. Weighted clients follow, and each is served only while its credit is not negative. Plain clients come last.

A grant is held for a whole packet. The arbiter only re-decides when the holder reports the end of its packet, or when no grant is held. Each WFQ credit register is tied to a client by a credit map. It earns its weight at every decision and is capped at an upper bound. The length of a finished packet is charged to the register of the client that sent it. The weights come from bandwidth shares through a load strobe. A run counter limits how many strict grants may follow one another while other work is waiting.

Top module: `tx_sched_arb`

## Requirements
- R1: Reset clears the grant, every credit, every weight and the strict run counter. After reset, weighted clients start at credit 0 and can be granted.
- R2: `gnt` is one-hot or zero and names only a client whose request was high at the deciding edge. A held grant changes only at an edge where `pkt_done` is high, and a decision is also taken on every edge where no grant is held.
- R3: `cfg_prio_map` holds one 3-bit client number per priority level. Level p sits at bits [3p+2:3p], and level 4 is the highest. Within a class, the requester at the highest level wins. A field value above 4 matches no client, and a client named in no field is never granted.
- R4: A pending strict request beats every weighted request, and an eligible weighted request beats every plain request. A client whose bit is set in `cfg_strict` is strict even if its `cfg_wfq` bit is also set.
- R5: A weighted client is eligible only when its credit, after the update of the deciding edge, is zero or more.
- R6: At every decision edge, each credit register adds its weight and saturates at CRD_BOUND (0x5000). On a `pkt_done` edge, `pkt_len` is then subtracted from the register mapped to the finishing client. Eligibility uses the result.
- R7: With `cfg_slots` = N > 0, after N consecutive strict grants an eligible weighted or plain request is served next, and this resets the run. With N = 0 there is no limit.
- R8: If the run limit is reached and no weighted or plain request is eligible, the strict winner is granted and the run count restarts at one.
- R9: On `bw_load`, weight k becomes floor(share_k × 0x5000 / sum of shares). A load in which any share is zero is ignored, and the previous weights stay in force.
- R10: `cfg_crd_map` field k (bits [3k+2:3k]) names the client of credit register k. A weighted client that no field names is always eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 5 | Per-client request |
| pkt_done | input | 1 | Current holder finished its packet |
| pkt_len | input | 16 | Length of the finished packet |
| cfg_prio_map | input | 15 | Client number per priority level |
| cfg_strict | input | 5 | Strict client bitmap |
| cfg_wfq | input | 5 | Weighted client bitmap |
| cfg_slots | input | 9 | Consecutive strict grant limit, 0 = none |
| cfg_crd_map | input | 6 | Client number per credit register |
| bw_load | input | 1 | Load weights from shares |
| bw_share | input | 16 | Bandwidth share per credit register, 8 bits each |
| gnt | output | 5 | One-hot grant |

## Verification
A wrong credit value shows on the grant at the very next decision edge, where a weighted client is skipped or served against the expected balance. The tests therefore drive credits across zero and into the bound, and read the result from the order of grants. A wrong run counter shows as a weighted or plain client that is served one packet too early or too late after a strict burst. Weights that were wrongly loaded or wrongly rejected show as clients that stay blocked, or that recover, after idle cycles.

// File: rtl/tx_sched_arb.sv
module tx_sched_arb #(
  parameter int NCLI      = 5,
  parameter int CID_W     = 3,
  parameter int NWREG     = 2,
  parameter int LEN_W     = 16,
  parameter int CRD_W     = 20,
  parameter int SLOT_W    = 9,
  parameter int SHARE_W   = 8,
  parameter int CRD_BOUND = 20480,
  parameter int WGT_SCALE = 20480
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCLI-1:0]           req,
  input  logic                      pkt_done,
  input  logic [LEN_W-1:0]          pkt_len,
  input  logic [NCLI*CID_W-1:0]     cfg_prio_map,
  input  logic [NCLI-1:0]           cfg_strict,
  input  logic [NCLI-1:0]           cfg_wfq,
  input  logic [SLOT_W-1:0]         cfg_slots,
  input  logic [NWREG*CID_W-1:0]    cfg_crd_map,
  input  logic                      bw_load,
  input  logic [NWREG*SHARE_W-1:0]  bw_share,
  output logic [NCLI-1:0]           gnt
);
  localparam int WGT_W = $clog2(WGT_SCALE + 1);
  localparam int TOT_W = SHARE_W + $clog2(NWREG) + 1;
  localparam int PRD_W = SHARE_W + WGT_W;
  localparam logic signed [CRD_W:0] BND = CRD_BOUND;

  logic [NCLI-1:0]          gnt_q;
  logic signed [CRD_W-1:0]  crd_q  [NWREG];
  logic signed [CRD_W-1:0]  crd_nx [NWREG];
  logic [WGT_W-1:0]         wgt_q  [NWREG];
  logic [WGT_W-1:0]         wgt_new[NWREG];
  logic [SLOT_W-1:0]        run_q;

  wire held = |gnt_q;
  wire done = pkt_done & held;
  wire tick = done | ~held;

  function automatic logic [NCLI-1:0] pick(input logic [NCLI-1:0] m,
                                           input logic [NCLI*CID_W-1:0] pm);
    logic [NCLI-1:0]  oh;
    logic [CID_W-1:0] id;
    pick = '0;
    for (int p = 0; p < NCLI; p++) begin
      id = pm[p*CID_W +: CID_W];
      oh = NCLI'(1) << id;
      if ((m & oh) != '0) pick = oh;
    end
  endfunction

  for (genvar k = 0; k < NWREG; k++) begin : g_crd
    logic [CID_W-1:0]  cm;
    logic              mine;
    logic signed [CRD_W:0] acc;
    assign cm   = cfg_crd_map[k*CID_W +: CID_W];
    assign mine = |(gnt_q & (NCLI'(1) << cm));
    always_comb begin
      acc = {crd_q[k][CRD_W-1], crd_q[k]} + $signed({{(CRD_W+1-WGT_W){1'b0}}, wgt_q[k]});
      if (acc > BND) acc = BND;
      crd_nx[k] = acc[CRD_W-1:0];
      if (done && mine)
        crd_nx[k] = acc[CRD_W-1:0] - $signed({{(CRD_W-LEN_W){1'b0}}, pkt_len});
    end
  end

  logic [NCLI-1:0] cok;
  always_comb begin
    cok = '1;
    for (int c = 0; c < NCLI; c++)
      for (int k = 0; k < NWREG; k++)
        if (cfg_crd_map[k*CID_W +: CID_W] == CID_W'(c) && crd_nx[k] < 0)
          cok[c] = 1'b0;
  end

  logic [TOT_W-1:0] tot;
  logic             shr_ok;
  always_comb begin
    tot    = '0;
    shr_ok = 1'b1;
    for (int k = 0; k < NWREG; k++) begin
      tot = tot + TOT_W'(bw_share[k*SHARE_W +: SHARE_W]);
      if (bw_share[k*SHARE_W +: SHARE_W] == '0) shr_ok = 1'b0;
    end
    for (int k = 0; k < NWREG; k++)
      wgt_new[k] = shr_ok
        ? WGT_W'((PRD_W'(bw_share[k*SHARE_W +: SHARE_W]) * PRD_W'(WGT_SCALE)) / PRD_W'(tot))
        : wgt_q[k];
  end

  wire [NCLI-1:0] st_e  = req & cfg_strict;
  wire [NCLI-1:0] wq_e  = req & ~cfg_strict & cfg_wfq & cok;
  wire [NCLI-1:0] pl_e  = req & ~cfg_strict & ~cfg_wfq;
  wire            lim   = (cfg_slots != '0) && (run_q >= cfg_slots);
  wire            blk   = lim && |(wq_e | pl_e);
  wire [NCLI-1:0] win_s = blk ? '0 : pick(st_e, cfg_prio_map);
  wire [NCLI-1:0] win_w = pick(wq_e, cfg_prio_map);
  wire [NCLI-1:0] win_p = pick(pl_e, cfg_prio_map);
  wire [NCLI-1:0] win   = |win_s ? win_s : (|win_w ? win_w : win_p);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= '0;
      run_q <= '0;
      for (int k = 0; k < NWREG; k++) begin
        crd_q[k] <= '0;
        wgt_q[k] <= '0;
      end
    end else begin
      if (tick) begin
        gnt_q <= win;
        for (int k = 0; k < NWREG; k++) crd_q[k] <= crd_nx[k];
        if (|win_s)
          run_q <= lim ? SLOT_W'(1) : ((cfg_slots == '0) ? run_q : run_q + SLOT_W'(1));
        else if (|win)
          run_q <= '0;
      end
      if (bw_load)
        for (int k = 0; k < NWREG; k++) wgt_q[k] <= wgt_new[k];
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/tx_sched_arb_chk.sv
module tx_sched_arb_chk #(
  parameter int NCLI      = 5,
  parameter int NWREG     = 2,
  parameter int CRD_W     = 20,
  parameter int SLOT_W    = 9,
  parameter int CRD_BOUND = 20480
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NCLI-1:0]          req,
  input logic                     pkt_done,
  input logic [NCLI-1:0]          gnt,
  input logic [SLOT_W-1:0]        cfg_slots,
  input logic [SLOT_W-1:0]        run_q,
  input logic signed [CRD_W-1:0]  crd_q [NWREG]
);
  localparam logic signed [CRD_W-1:0] BND = CRD_BOUND;

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt && !pkt_done) |=> $stable(gnt));

  a_r2_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt && !$stable(gnt)) |-> |($past(req) & gnt));

  a_r7_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slots != '0) |-> (run_q <= cfg_slots));

  for (genvar k = 0; k < NWREG; k++) begin : g_bnd
    a_r6_credit_cap: assert property (@(posedge clk) disable iff (!rst_n)
      crd_q[k] <= BND);
  end
endmodule

bind tx_sched_arb tx_sched_arb_chk #(
  .NCLI(NCLI), .NWREG(NWREG), .CRD_W(CRD_W), .SLOT_W(SLOT_W), .CRD_BOUND(CRD_BOUND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .pkt_done(pkt_done), .gnt(gnt),
  .cfg_slots(cfg_slots), .run_q(run_q), .crd_q(crd_q)
);

// File: tb/test_tx_sched_arb.sv
module test_tx_sched_arb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  req = '0;
  logic        pkt_done = 0;
  logic [15:0] pkt_len = '0;
  logic [14:0] cfg_prio_map = 15'h4688;
  logic [4:0]  cfg_strict = '0;
  logic [4:0]  cfg_wfq = '0;
  logic [8:0]  cfg_slots = '0;
  logic [5:0]  cfg_crd_map = 6'b100_011;
  logic        bw_load = 0;
  logic [15:0] bw_share = '0;
  logic [4:0]  gnt;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tx_sched_arb i_tx_sched_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .cfg_prio_map(cfg_prio_map), .cfg_strict(cfg_strict), .cfg_wfq(cfg_wfq),
    .cfg_slots(cfg_slots), .cfg_crd_map(cfg_crd_map), .bw_load(bw_load),
    .bw_share(bw_share), .gnt(gnt)
  );

  task automatic chk(input string tag, input logic [4:0] exp);
    n_run++;
    if (gnt !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt=%b expected %b", tag, gnt, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_pkt(input logic [15:0] len);
    pkt_done = 1; pkt_len = len;
    @(negedge clk);
    pkt_done = 0; pkt_len = '0;
  endtask

  task automatic rst_cfg(input logic [14:0] pm, input logic [4:0] st, input logic [4:0] wq,
                         input logic [8:0] sl, input logic [5:0] cm);
    @(negedge clk);
    rst_n = 0; req = '0;
    cfg_prio_map = pm; cfg_strict = st; cfg_wfq = wq; cfg_slots = sl; cfg_crd_map = cm;
    cyc(2);
    rst_n = 1;
  endtask

  task automatic load_bw(input logic [7:0] s0, input logic [7:0] s1);
    bw_share = {s1, s0}; bw_load = 1;
    @(negedge clk);
    bw_load = 0;
  endtask

  task automatic t_reset;
    rst_cfg(15'h4688, 5'h1F, 5'h00, 9'd0, 6'b100_011);
    cyc(1);
    chk("R1 idle after reset", 5'b00000);
    rst_cfg(15'h4688, 5'h00, 5'h18, 9'd0, 6'b100_011);
    req = 5'b11000; cyc(1);
    chk("R1 start credit", 5'b10000);
    done_pkt(5); chk("R5 class1 blocked", 5'b01000);
    done_pkt(5); chk("R5 both blocked", 5'b00000);
    rst_n = 0; cyc(1);
    chk("R1 gnt in reset", 5'b00000);
    rst_n = 1; cyc(1);
    chk("R1 credits cleared", 5'b10000);
  endtask

  task automatic t_prio;
    rst_cfg(15'h4688, 5'h1F, 5'h00, 9'd0, 6'b100_011);
    req = 5'b00111; cyc(1);
    chk("R3 highest level", 5'b00100);
    req = 5'b00011; cyc(3);
    chk("R2 hold without done", 5'b00100);
    done_pkt(0); chk("R3 next level", 5'b00010);
    req = 5'b00000; done_pkt(0);
    chk("R2 release", 5'b00000);
    rst_cfg(15'h22E0, 5'h1F, 5'h00, 9'd0, 6'b100_011);
    req = 5'b11000; cyc(1);
    chk("R3 remapped", 5'b01000);
    rst_cfg(15'h78D1, 5'h1F, 5'h00, 9'd0, 6'b100_011);
    req = 5'b11000; cyc(1);
    chk("R3 invalid field", 5'b10000);
    req = 5'b00001; done_pkt(0);
    chk("R3 unmapped client", 5'b00000);
  endtask

  task automatic t_class;
    rst_cfg(15'h4688, 5'h07, 5'h18, 9'd0, 6'b100_011);
    req = 5'b11001; cyc(1);
    chk("R4 strict first", 5'b00001);
    req = 5'b11000; done_pkt(0);
    chk("R4 wfq by level", 5'b10000);
    rst_cfg(15'h22E0, 5'h01, 5'h10, 9'd0, 6'b100_011);
    req = 5'b10010; cyc(1);
    chk("R4 wfq over plain", 5'b10000);
    req = 5'b00010; done_pkt(0);
    chk("R4 plain served", 5'b00010);
    rst_cfg(15'h4688, 5'h11, 5'h10, 9'd0, 6'b100_011);
    req = 5'b10010; cyc(1);
    chk("R4 strict over wfq bit", 5'b10000);
  endtask

  task automatic t_credit;
    rst_cfg(15'h4688, 5'h00, 5'h18, 9'd0, 6'b100_011);
    load_bw(8'd1, 8'd3); cyc(6);
    req = 5'b11000; cyc(1);
    chk("R6 saturated start", 5'b10000);
    done_pkt(40000); chk("R5 negative credit", 5'b01000);
    done_pkt(0);     chk("R6 still negative", 5'b01000);
    done_pkt(0);     chk("R6 recovered", 5'b10000);
    done_pkt(20481); chk("R6 cap then debit", 5'b01000);
  endtask

  task automatic t_map;
    rst_cfg(15'h4688, 5'h00, 5'h18, 9'd0, 6'b011_100);
    load_bw(8'd1, 8'd3); cyc(6);
    req = 5'b11000; cyc(1);
    chk("R10 start", 5'b10000);
    done_pkt(40000); chk("R10 swapped debit", 5'b01000);
    done_pkt(0); done_pkt(0);
    chk("R10 swapped weight", 5'b01000);
    rst_cfg(15'h4688, 5'h00, 5'h18, 9'd0, 6'b111_111);
    req = 5'b11000; cyc(1);
    for (int i = 0; i < 3; i++) done_pkt(16'hFFFF);
    chk("R10 unmapped never blocked", 5'b10000);
  endtask

  task automatic t_bw;
    rst_cfg(15'h4688, 5'h00, 5'h18, 9'd0, 6'b100_011);
    load_bw(8'd0, 8'd5);
    req = 5'b11000; cyc(1);
    chk("R9 first grant", 5'b10000);
    done_pkt(1); done_pkt(1);
    cyc(5);
    chk("R9 zero share ignored", 5'b00000);
    load_bw(8'd3, 8'd0); cyc(5);
    chk("R9 second reject", 5'b00000);
    load_bw(8'd1, 8'd1); cyc(1);
    chk("R9 valid load", 5'b10000);
  endtask

  task automatic t_slots;
    rst_cfg(15'h4688, 5'h07, 5'h18, 9'd2, 6'b100_011);
    req = 5'b01001; cyc(1);
    chk("R7 strict 1", 5'b00001);
    done_pkt(0); chk("R7 strict 2", 5'b00001);
    done_pkt(0); chk("R7 limit yields", 5'b01000);
    done_pkt(0); chk("R7 run restarts", 5'b00001);
    rst_cfg(15'h4688, 5'h07, 5'h18, 9'd2, 6'b100_011);
    req = 5'b00001; cyc(1);
    done_pkt(0); done_pkt(0);
    chk("R8 strict past limit", 5'b00001);
    req = 5'b01001; done_pkt(0);
    chk("R8 count reloaded", 5'b00001);
    done_pkt(0); chk("R7 yield after reload", 5'b01000);
    rst_cfg(15'h4688, 5'h07, 5'h18, 9'd0, 6'b100_011);
    req = 5'b01001; cyc(1);
    for (int i = 0; i < 4; i++) done_pkt(0);
    chk("R7 no limit", 5'b00001);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_prio();
    t_class();
    t_credit();
    t_map();
    t_bw();
    t_slots();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule